// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier (Unsigned and Two's-Complement)

This block multiplies two W-bit operands over W clock cycles using one shared adder/subtractor. A start pulse loads the multiplicand and the multiplier and clears the double-width partial product. A mode input selects unsigned or two's-complement operation.

Each cycle examines one multiplier bit, beginning with the least significant. That bit steers a two-way select between zero and the multiplicand. The selected value is combined with the upper half of the partial product, and the (W+1)-bit result is shifted one place right into the double-width register. The multiplier register shifts right in the same cycle, so its next bit reaches the select. In two's-complement mode both adder inputs are sign-extended and the step for the top multiplier bit subtracts instead of adding. In unsigned mode the adder's carry-out is the bit that enters the top of the partial product.

The block raises a busy flag for the W steps. A one-cycle done pulse then marks the 2W-bit product as valid, and the product stays on its output until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and at the first clock after its release, busy and done are 0 and the product output is all zeros.
- R2: A start seen while idle is accepted at that clock edge. Busy is then 1 for exactly W consecutive cycles, beginning the cycle after the edge.
- R3: Done is 1 for exactly one cycle, the cycle immediately after the last busy cycle. Busy and done are never 1 together.
- R4: With the mode input at 0 (unsigned), the product equals x*y, both read as unsigned W-bit integers, over all 2W bits.
- R5: With the mode input at 1 (two's-complement), the product equals x*y, both read as signed W-bit integers, as a 2W-bit two's-complement value. This covers a negative multiplier, whose top-bit step subtracts.
- R6: The extreme operands give exact results without overflow: all ones times all ones unsigned, and the most negative value times itself and times the most positive value signed.
- R7: While busy, start pulses and changes on x, y and the mode input have no effect on the running operation or on its result.
- R8: Once done has been raised, the product output holds its value until the next accepted start, whatever x, y and the mode input do.
- R9: A start given in the same cycle that done is high is accepted, and the new operation completes with its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| x_i | input | W | Multiplicand |
| y_i | input | W | Multiplier |
| busy_o | output | 1 | High during the W shift-add steps |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| prod_o | output | 2W | Double-width product |

## Verification
The embedded assertions watch the control timing on every cycle. They check that busy and done are exclusive and that done lasts one cycle. They also check that an idle start always leads to busy, that busy runs exactly W cycles before done, that a start during busy does not cut a run short, and that the product stays stable while idle with no start. The numerical behaviour can only be shown by the bench scenarios. These cover the unsigned carry-out path, the subtracting final step for a negative multiplier, the extreme operands and the discarding of operand changes made while busy. A behavioural model running beside the design compares busy, done and the held product on every clock.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_addsub.sv
// N-bit ripple adder/subtractor: sum = a + b, or a - b when sub_i is 1.
module smul_addsub #(
  parameter int N = 9
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o
);
  logic [N:0]   carry;
  logic [N-1:0] b_inv;

  assign carry[0] = sub_i;
  assign b_inv    = b_i ^ {N{sub_i}};

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_inv[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_inv[i]) | (carry[i] & (a_i[i] ^ b_inv[i]));
  end
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o,
  output logic last_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int RW = $clog2(W + 1) + 1;

  smul_state_e   state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    last_o  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_n = S_RUN;
          cnt_n   = '0;
        end
      end
      S_RUN: begin
        step_o = 1'b1;
        cnt_n  = cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          last_o  = 1'b1;
          state_n = S_IDLE;
          done_n  = 1'b1;
          cnt_n   = '0;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      done_q  <= done_n;
    end
  end

  assign busy_o = (state_q == S_RUN);
  assign done_o = done_q;

  // Checker-only count of consecutive busy cycles.
  logic [RW-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else run_len_q <= '0;
  end

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len_q == RW'(W)));
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && (run_len_q < RW'(W - 1))) |=> (busy_o && !done_o));
endmodule

// File: rtl/smul_dpath.sv
module smul_dpath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic           signed_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] prod_o
);
  localparam int N = W + 1;

  logic [W-1:0] mcand_q, mcand_n;
  logic [W-1:0] mplier_q, mplier_n;
  logic [W-1:0] zhi_q, zhi_n;
  logic [W-1:0] zlo_q, zlo_n;
  logic         sgn_q, sgn_n;

  logic [W-1:0] addend;
  logic [N-1:0] op_a, op_b, sum;
  logic         sub_en;

  // Select zero or the multiplicand from the current multiplier bit.
  assign addend = mplier_q[0] ? mcand_q : '0;
  assign op_a   = {sgn_q & zhi_q[W-1], zhi_q};
  assign op_b   = {sgn_q & addend[W-1], addend};
  assign sub_en = sgn_q & last_i;

  smul_addsub #(.N(N)) u_addsub (
    .a_i  (op_a),
    .b_i  (op_b),
    .sub_i(sub_en),
    .sum_o(sum)
  );

  always_comb begin
    mcand_n  = mcand_q;
    mplier_n = mplier_q;
    zhi_n    = zhi_q;
    zlo_n    = zlo_q;
    sgn_n    = sgn_q;
    if (load_i) begin
      mcand_n  = x_i;
      mplier_n = y_i;
      zhi_n    = '0;
      zlo_n    = '0;
      sgn_n    = signed_i;
    end else if (step_i) begin
      zhi_n    = sum[N-1:1];
      zlo_n    = {sum[0], zlo_q[W-1:1]};
      mplier_n = {1'b0, mplier_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      zhi_q    <= '0;
      zlo_q    <= '0;
      sgn_q    <= 1'b0;
    end else if (load_i || step_i) begin
      mcand_q  <= mcand_n;
      mplier_q <= mplier_n;
      zhi_q    <= zhi_n;
      zlo_q    <= zlo_n;
      sgn_q    <= sgn_n;
    end
  end

  assign prod_o = {zhi_q, zlo_q};

  // The operands captured at load stay fixed for the whole run.
  assert_operand_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_i) |=> ($stable(mcand_q) && $stable(sgn_q)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  logic load, step, last;

  smul_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .load_o (load),
    .step_o (step),
    .last_o (last)
  );

  smul_dpath #(.W(W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .last_i  (last),
    .signed_i(signed_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .prod_o  (prod_o)
  );

  assert_prod_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(prod_o));
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic           signed_i;
  logic [W-1:0]   x_i, y_i;
  logic           busy_o, done_o;
  logic [2*W-1:0] prod_o;

  int tests;
  int fails;

  shift_add_mul #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .x_i(x_i), .y_i(y_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic sgn);
    logic [2*W-1:0] ea, eb;
    ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  // Behavioural model, updated on the same edge as the design.
  logic           m_busy, m_done;
  int             m_cnt;
  logic [2*W-1:0] m_prod, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_prod = '0; m_res = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == W) begin
          m_busy = 1'b0; m_done = 1'b1; m_prod = m_res;
        end
      end else if (start_i) begin
        m_busy = 1'b1; m_cnt = 0; m_res = ref_mul(x_i, y_i, signed_i);
      end
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (busy_o !== m_busy) begin
        fails++; $display("FAIL R2 busy: actual %b expected %b", busy_o, m_busy);
      end
      tests++;
      if (done_o !== m_done) begin
        fails++; $display("FAIL R3 done: actual %b expected %b", done_o, m_done);
      end
      if (!m_busy) begin
        tests++;
        if (prod_o !== m_prod) begin
          fails++; $display("FAIL R8 held product: actual %h expected %h", prod_o, m_prod);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++; $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Caller is at a falling edge; returns at the falling edge where done is seen.
  task automatic run_op(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sgn, input bit disturb);
    int lat;
    start_i = 1'b1; x_i = a; y_i = b; signed_i = sgn;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < W + 6) begin
      if (disturb) begin
        start_i = 1'b1; x_i = ~a; y_i = b + 8'd3; signed_i = ~sgn;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    check({tag, " R2 latency"}, (2*W)'(lat), (2*W)'(W + 1));
    check(tag, prod_o, ref_mul(a, b, sgn));
  endtask

  initial begin
    tests = 0; fails = 0;
    start_i = 1'b0; signed_i = 1'b0; x_i = '0; y_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset product", prod_o, '0);
    check("R1 reset flags", {14'd0, busy_o, done_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {prod_o[13:0], busy_o, done_o}, '0);

    run_op("R4 unsigned 10x3", 8'd10, 8'd3, 1'b0, 0);
    run_op("R4 unsigned 0xA5x0x3C", 8'hA5, 8'h3C, 1'b0, 0);
    run_op("R4 unsigned zero", 8'h00, 8'h7F, 1'b0, 0);
    run_op("R5 signed -6x3", 8'hFA, 8'h03, 1'b1, 0);
    run_op("R5 signed -6x-5", 8'hFA, 8'hFB, 1'b1, 0);
    run_op("R5 signed 7x-1", 8'h07, 8'hFF, 1'b1, 0);
    run_op("R6 unsigned max", 8'hFF, 8'hFF, 1'b0, 0);
    run_op("R6 signed min x min", 8'h80, 8'h80, 1'b1, 0);
    run_op("R6 signed min x max", 8'h80, 8'h7F, 1'b1, 0);
    // R9: start again in the done cycle
    run_op("R9 back-to-back", 8'h12, 8'hC4, 1'b1, 0);
    check("R3 done one cycle", {15'd0, done_o}, 16'd1);
    @(negedge clk);
    check("R3 done cleared", {15'd0, done_o}, 16'd0);
    // R7: disturb inputs throughout the run
    run_op("R7 ignore while busy", 8'h9C, 8'h37, 1'b1, 1);
    // R8: inputs change while idle, product holds
    x_i = 8'h55; y_i = 8'hAA; signed_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 hold after done", prod_o, ref_mul(8'h9C, 8'h37, 1'b1));
    @(negedge clk);
    run_op("R4 unsigned after hold", 8'h80, 8'h02, 1'b0, 0);
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule